// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block arbitrates twelve interrupt sources for a small 8-bit processor and supports two priority levels. Each source has an enable bit and a priority bit, and a global enable gates every source. The block takes the raw flags that the timers, the two serial channels, the watchdog and the external-pin logic produce. Where a peripheral raises two flags for one source, the block merges them into one request. It then presents the winning request to the processor as an interrupt line and a 4-bit vector index.

When the processor acknowledges, the block records which level is now in service. In the same cycle it emits a one-cycle clear strobe toward the flag owner, but only for sources whose policy is a hardware clear. A return-from-interrupt pulse closes the innermost active level.

The nesting tracker is a four-state machine:
- **IDLE**: no handler is running.
- **LOW**: a low-priority handler is running.
- **HIGH**: a high-priority handler entered from IDLE is running.
- **NEST**: a high-priority handler has preempted a low one.

The machine has these transitions:
- IDLE→LOW on a granted acknowledge of a low source.
- IDLE→HIGH on a granted acknowledge of a high source.
- LOW→NEST on a granted acknowledge, which can only be for a high source.
- LOW→IDLE, HIGH→IDLE and NEST→LOW on return.

Top module: `intc_two_level`

## Requirements
- R1: The source indices are: 0 external line 0, 1 timer 0, 2 external line 1, 3 timer 1, 4 serial channel 0, 5 timer 2, 6 serial channel 1, 7 to 10 external lines 2 to 5, and 11 watchdog. Serial channel n requests on its receive OR transmit flag. Timer 2 requests on its overflow OR capture flag. The watchdog requests only when its timeout flag AND its interrupt enable are both 1.
- R2: A source takes part only when its enable bit `en_i[idx]` is 1 and `global_en_i` is 1. When `global_en_i` is 0, `irq_o` is 0.
- R3: Where a source is allowed at both levels, a pending source whose priority bit `prio_i[idx]` is 1 beats any pending source whose priority bit is 0.
- R4: Among pending sources of the same level, the lowest index wins. `vec_o` carries that index whenever `irq_o` is 1.
- R5: In LOW, only sources with priority bit 1 raise `irq_o`. Low-priority requests are held off.
- R6: In HIGH and NEST, `irq_o` stays 0 whatever is pending.
- R7: A return pulse moves NEST to LOW, and moves LOW or HIGH to IDLE. A return pulse in IDLE has no effect.
- R8: In the cycle `ack_i` is granted, `clr_o` has at most the bit of the acknowledged index set. Timers 0 and 1 are always cleared. External line k is cleared only when `ext_hwclr_i[k]` is 1. Serial, timer 2 and watchdog sources are never cleared.
- R9: An acknowledge while `irq_o` is 0 is ignored. An acknowledge in the same cycle as a return pulse is ignored and the return is taken. In both cases `clr_o` stays 0.
- R10: After reset the machine is in IDLE and `clr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_flag_i | input | 6 | External line flags 0..5 |
| ext_hwclr_i | input | 6 | Per external line: clear on acknowledge |
| tmr_ovf_i | input | 2 | Timer 0 and timer 1 overflow flags |
| t2_ovf_i | input | 1 | Timer 2 overflow flag |
| t2_cap_i | input | 1 | Timer 2 capture/reload flag |
| ser_rx_i | input | 2 | Serial channel receive flags |
| ser_tx_i | input | 2 | Serial channel transmit flags |
| wdt_flag_i | input | 1 | Watchdog timeout flag |
| wdt_irq_en_i | input | 1 | Watchdog interrupt enable |
| en_i | input | 12 | Per-source enable |
| prio_i | input | 12 | Per-source priority (1 = high) |
| global_en_i | input | 1 | Global enable |
| ack_i | input | 1 | Vector acknowledge pulse |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request to processor |
| vec_o | output | 4 | Winning source index |
| clr_o | output | 12 | Hardware clear strobe per source |

## Verification
The embedded properties check on every cycle that:
- a presented vector is enabled under the global gate;
- `irq_o` is silent in HIGH and NEST;
- only high vectors appear in LOW;
- the clear strobe is at most one bit and only accompanies a granted acknowledge;
- NEST always unwinds to LOW.

Only the bench scenarios can show several things: that the flag merging and the index order match the source map, that the per-line clear selection picks the right sources, and that a full preempt-and-return sequence restores the right level. For these, a behavioural model in the bench is compared with the outputs every cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC  = 12;
    localparam int NEXT  = 6;
    localparam int VECW  = $clog2(NSRC);

    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER0 = 4;
    localparam int SRC_TMR2 = 5;
    localparam int SRC_SER1 = 6;
    localparam int SRC_EXT2 = 7;
    localparam int SRC_WDT  = 11;

    typedef enum logic [1:0] {
        LV_IDLE = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_NEST = 2'd3
    } lvl_e;
endpackage

// File: rtl/intc_req_merge.sv
module intc_req_merge
    import intc_pkg::*;
(
    input  logic [NEXT-1:0] ext_flag_i,
    input  logic [NEXT-1:0] ext_hwclr_i,
    input  logic [1:0]      tmr_ovf_i,
    input  logic            t2_ovf_i,
    input  logic            t2_cap_i,
    input  logic [1:0]      ser_rx_i,
    input  logic [1:0]      ser_tx_i,
    input  logic            wdt_flag_i,
    input  logic            wdt_irq_en_i,
    output logic [NSRC-1:0] raw_o,
    output logic [NSRC-1:0] hwclr_o
);
    localparam int NHI_EXT = NEXT - 2;

    always_comb begin
        raw_o   = '0;
        hwclr_o = '0;
        // fixed-position sources (R1)
        raw_o[SRC_EXT0] = ext_flag_i[0];
        raw_o[SRC_TMR0] = tmr_ovf_i[0];
        raw_o[SRC_EXT1] = ext_flag_i[1];
        raw_o[SRC_TMR1] = tmr_ovf_i[1];
        raw_o[SRC_SER0] = ser_rx_i[0] | ser_tx_i[0];
        raw_o[SRC_TMR2] = t2_ovf_i | t2_cap_i;
        raw_o[SRC_SER1] = ser_rx_i[1] | ser_tx_i[1];
        raw_o[SRC_WDT]  = wdt_flag_i & wdt_irq_en_i;
        // clear policy (R8): timers always, external lines by select
        hwclr_o[SRC_TMR0] = 1'b1;
        hwclr_o[SRC_TMR1] = 1'b1;
        hwclr_o[SRC_EXT0] = ext_hwclr_i[0];
        hwclr_o[SRC_EXT1] = ext_hwclr_i[1];
        for (int k = 0; k < NHI_EXT; k++) begin
            raw_o[SRC_EXT2 + k]   = ext_flag_i[2 + k];
            hwclr_o[SRC_EXT2 + k] = ext_hwclr_i[2 + k];
        end
    end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int N = 12,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [5:0]      ext_flag_i,
    input  logic [5:0]      ext_hwclr_i,
    input  logic [1:0]      tmr_ovf_i,
    input  logic            t2_ovf_i,
    input  logic            t2_cap_i,
    input  logic [1:0]      ser_rx_i,
    input  logic [1:0]      ser_tx_i,
    input  logic            wdt_flag_i,
    input  logic            wdt_irq_en_i,
    input  logic [11:0]     en_i,
    input  logic [11:0]     prio_i,
    input  logic            global_en_i,
    input  logic            ack_i,
    input  logic            reti_i,
    output logic            irq_o,
    output logic [3:0]      vec_o,
    output logic [11:0]     clr_o
);
    logic [NSRC-1:0] raw, hwclr, pend;
    logic [NSRC-1:0] lvl_req [2];
    logic            found   [2];
    logic [VECW-1:0] idx     [2];
    lvl_e            state_q, state_d;
    logic            allow_hi, allow_lo, hi_sel, take;

    intc_req_merge u_merge (
        .ext_flag_i   (ext_flag_i),
        .ext_hwclr_i  (ext_hwclr_i),
        .tmr_ovf_i    (tmr_ovf_i),
        .t2_ovf_i     (t2_ovf_i),
        .t2_cap_i     (t2_cap_i),
        .ser_rx_i     (ser_rx_i),
        .ser_tx_i     (ser_tx_i),
        .wdt_flag_i   (wdt_flag_i),
        .wdt_irq_en_i (wdt_irq_en_i),
        .raw_o        (raw),
        .hwclr_o      (hwclr)
    );

    assign pend       = raw & en_i & {NSRC{global_en_i}};
    assign lvl_req[0] = pend & ~prio_i;
    assign lvl_req[1] = pend & prio_i;

    for (genvar g = 0; g < 2; g++) begin : g_lvl
        intc_pick #(.N(NSRC), .W(VECW)) u_pick (
            .req_i   (lvl_req[g]),
            .found_o (found[g]),
            .idx_o   (idx[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_IDLE: if (take)   state_d = hi_sel ? LV_HIGH : LV_LOW;
            LV_LOW:  if (reti_i) state_d = LV_IDLE;
                     else if (take) state_d = LV_NEST;
            LV_HIGH: if (reti_i) state_d = LV_IDLE;
            LV_NEST: if (reti_i) state_d = LV_LOW;
            default: state_d = LV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        allow_hi = (state_q == LV_IDLE) || (state_q == LV_LOW);
        allow_lo = (state_q == LV_IDLE);
        hi_sel   = allow_hi && found[1];
        irq_o    = hi_sel || (allow_lo && found[0]);
        vec_o    = hi_sel ? idx[1] : idx[0];
        take     = ack_i && irq_o && !reti_i;
        clr_o    = take ? (hwclr & (NSRC'(1) << vec_o)) : '0;
    end

    p_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (global_en_i && en_i[vec_o]));
    p_low_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_LOW && irq_o) |-> prio_i[vec_o]);
    p_high_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_HIGH || state_q == LV_NEST) |-> !irq_o);
    p_nest_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_NEST && reti_i) |=> (state_q == LV_LOW));
    p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));
    p_clr_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> (ack_i && irq_o && !reti_i));
endmodule

// File: tb/intc_two_level_bench.sv
`timescale 1ns/1ps
module intc_two_level_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ext_flag = '0, ext_hwclr = '0;
    logic [1:0]  tmr_ovf = '0, ser_rx = '0, ser_tx = '0;
    logic        t2_ovf = 1'b0, t2_cap = 1'b0, wdt_flag = 1'b0, wdt_en = 1'b0;
    logic [11:0] en = '0, prio = '0;
    logic        gen = 1'b0, ack = 1'b0, reti = 1'b0;
    logic        irq;
    logic [3:0]  vec;
    logic [11:0] clr;

    int checks = 0;
    int errors = 0;
    int lvl = 0; // 0 idle, 1 low, 2 high, 3 nested
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intc_two_level u_intc_two_level (
        .clk(clk), .rst_n(rst_n), .ext_flag_i(ext_flag), .ext_hwclr_i(ext_hwclr),
        .tmr_ovf_i(tmr_ovf), .t2_ovf_i(t2_ovf), .t2_cap_i(t2_cap),
        .ser_rx_i(ser_rx), .ser_tx_i(ser_tx), .wdt_flag_i(wdt_flag),
        .wdt_irq_en_i(wdt_en), .en_i(en), .prio_i(prio), .global_en_i(gen),
        .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_o(vec), .clr_o(clr)
    );

    function automatic bit src_req(int i);
        case (i)
            0: return ext_flag[0];
            1: return tmr_ovf[0];
            2: return ext_flag[1];
            3: return tmr_ovf[1];
            4: return ser_rx[0] | ser_tx[0];
            5: return t2_ovf | t2_cap;
            6: return ser_rx[1] | ser_tx[1];
            11: return wdt_flag & wdt_en;
            default: return ext_flag[i - 5];
        endcase
    endfunction

    function automatic bit src_clr(int i);
        if (i == 1 || i == 3) return 1'b1;
        if (i == 0) return ext_hwclr[0];
        if (i == 2) return ext_hwclr[1];
        if (i >= 7 && i <= 10) return ext_hwclr[i - 5];
        return 1'b0;
    endfunction

    task automatic step(input string tag);
        int win;
        bit e_irq, win_hi;
        logic [11:0] e_clr;
        #1;
        win = -1;
        win_hi = 1'b0;
        if (lvl <= 1)
            for (int i = 0; i < 12; i++)
                if (win < 0 && gen && en[i] && prio[i] && src_req(i)) begin
                    win = i; win_hi = 1'b1;
                end
        if (lvl == 0 && win < 0)
            for (int i = 0; i < 12; i++)
                if (win < 0 && gen && en[i] && !prio[i] && src_req(i)) win = i;
        e_irq = (win >= 0);
        e_clr = '0;
        if (e_irq && ack && !reti && src_clr(win)) e_clr[win] = 1'b1;
        checks++;
        if (irq !== e_irq) begin
            errors++;
            $display("FAIL %s irq_o actual %b expected %b", tag, irq, e_irq);
        end
        if (e_irq) begin
            checks++;
            if (vec !== 4'(win)) begin
                errors++;
                $display("FAIL %s vec_o actual %0d expected %0d", tag, vec, win);
            end
        end
        checks++;
        if (clr !== e_clr) begin
            errors++;
            $display("FAIL %s clr_o actual %h expected %h", tag, clr, e_clr);
        end
        @(posedge clk);
        if (reti) begin
            if (lvl == 3) lvl = 1;
            else if (lvl != 0) lvl = 0;
        end else if (ack && e_irq) begin
            if (lvl == 1) lvl = 3;
            else lvl = win_hi ? 2 : 1;
        end
        @(negedge clk);
        ack = 1'b0;
        reti = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R10 reset idle");
        gen = 1'b1;
        en = 12'hFFF;
        // R1 merged requests
        t2_cap = 1'b1;             step("R1 timer2 capture");
        t2_cap = 1'b0; t2_ovf = 1'b1; step("R1 timer2 overflow");
        t2_ovf = 1'b0; ser_tx[1] = 1'b1; step("R1 serial1 transmit");
        ser_tx[1] = 1'b0; ser_rx[0] = 1'b1; step("R1 serial0 receive");
        ser_rx[0] = 1'b0; wdt_flag = 1'b1; step("R1 watchdog gated off");
        wdt_en = 1'b1;             step("R1 watchdog enabled");
        wdt_flag = 1'b0;
        // R2 enables
        ext_flag[3] = 1'b1; en[8] = 1'b0; step("R2 source disabled");
        en[8] = 1'b1; gen = 1'b0;  step("R2 global off");
        gen = 1'b1;                step("R2 global on");
        // R4 lowest index
        ext_flag[3] = 1'b0; tmr_ovf[1] = 1'b1; ext_flag[0] = 1'b1;
        step("R4 lowest index wins");
        // R3 high beats low
        prio[3] = 1'b1;            step("R3 high over lower index");
        // R8 timer clear, enter HIGH
        ack = 1'b1;                step("R8 timer1 cleared on ack");
        tmr_ovf[1] = 1'b0; tmr_ovf[0] = 1'b1; prio[1] = 1'b1;
        step("R6 high handler blocks all");
        reti = 1'b1;               step("R7 high returns to idle");
        tmr_ovf[0] = 1'b0;
        // enter LOW via ext0 with no hw clear
        ack = 1'b1;                step("R8 ext0 not cleared");
        ext_flag[1] = 1'b1;        step("R5 low request held in low");
        tmr_ovf[0] = 1'b1;         step("R5 high preempts low");
        ack = 1'b1;                step("R8 timer0 cleared on preempt");
        step("R6 nested blocks all");
        tmr_ovf[0] = 1'b0; reti = 1'b1; step("R7 nest return");
        tmr_ovf[1] = 1'b1;         step("R7 back in low, high allowed");
        tmr_ovf[1] = 1'b0;         step("R7 low still holds low");
        reti = 1'b1;               step("R7 low returns to idle");
        // R9 ignored acknowledges
        ext_flag = '0; ack = 1'b1; step("R9 ack with no request");
        ext_flag[4] = 1'b1; ext_hwclr[4] = 1'b1; ack = 1'b1; reti = 1'b1;
        step("R9 ack with return ignored");
        reti = 1'b1;               step("R7 return in idle ignored");
        ack = 1'b1;                step("R8 ext4 cleared by select");
        reti = 1'b1;               step("R7 low returns");
        ext_flag = '0;             step("R10 quiet");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule